// File: doc/BRIEF.md
# Decade Counter Chain with Selectable Entry Stage

This block counts rising edges of an external pulse line. The count is kept in a chain of BCD decade stages, and the pulse can enter the chain at one of four stages. Entering higher up the chain divides the input by a power of ten. Used together with a gate period of 1 s or 0.1 s, the entry stage sets both the range and the resolution of a frequency reading. The same chain also serves as a plain event counter: the pulse then enters at the lowest stage shown on the display, so each pulse adds one to the first shown digit.

Only the upper digits go to the display. They are copied into a holding register when the latch enable is high, so the shown value stays fixed while the next count builds up. A carry out of the top stage sets a sticky overflow flag. A second flag takes the value of the sticky flag at each latch and is shown next to the digits. The usual gate cycle is: pulse the latch enable, then pulse the counter clear, then count again.

Top module: `bcd_range_counter`

## Requirements
- R1: Every stage holds a BCD value from 0 to 9. A stage advances by one when the stage below it rolls over from 9 to 0.
- R2: The entry select code works as follows: 00 injects at stage 0, 01 at stage 1, 10 at stage 3 and 11 at stage 4. One injected pulse adds ten to the power of that stage number to the chain value.
- R3: `cnt_in` passes through two synchronizer flops and an edge detector. Each low-to-high transition is counted once, and the chain advances on the third rising clock edge after the transition.
- R4: The shown digits are stages 3 to 7. Bits [3:0] of `disp_digits` carry stage 3 and bits [19:16] carry stage 7.
- R5: At a clock edge with `latch_en` high, the display register takes the chain value held before that edge. Any count or clear in the same cycle does not appear in the display.
- R6: While `latch_en` is low, `disp_digits` and `disp_ovf` do not change.
- R7: A carry out of stage 7 sets an internal overflow flag. The flag stays set until `clr`. The chain wraps to zero and keeps counting.
- R8: `disp_ovf` takes the value the overflow flag had before the edge, at each edge where `latch_en` is high.
- R9: `clr` clears all stages and the overflow flag at the next edge and takes priority over a count event in the same cycle. It leaves the display register unchanged.
- R10: When `rst_n` is low, all stages, both flags and the display register clear at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | 1 | Raw pulse line to be counted, asynchronous |
| entry_sel | input | 2 | Entry stage code (00 to stage 0, 01 to 1, 10 to 3, 11 to 4) |
| clr | input | 1 | Synchronous clear of the chain and the overflow flag |
| latch_en | input | 1 | Loads the display register at this edge |
| disp_digits | output | 20 | Five held BCD digits, least significant digit in the low bits |
| disp_ovf | output | 1 | Held overflow indicator |

## Verification
A latch and a count event can fall on the same edge, and so can a latch and a clear. In both cases the display must take the value from before that edge. The bench causes these collisions by holding `latch_en` high over long stretches while pulses arrive, and by raising `clr` and `latch_en` together with a pulse edge in progress. A behavioural model keeps the chain as one integer with power-of-ten weights and is compared with the outputs on every cycle. Any ordering error therefore shows up as a one-cycle mismatch.

// File: rtl/bcd_range_counter.sv
module bcd_range_counter #(
  parameter int NSTAGES = 8,
  parameter int NSHOW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_in,
  input  logic [1:0]           entry_sel,
  input  logic                 clr,
  input  logic                 latch_en,
  output logic [4*NSHOW-1:0]   disp_digits,
  output logic                 disp_ovf
);
  localparam int LOWEST = NSTAGES - NSHOW;

  logic [2:0] sh;
  logic       pulse;
  logic [3:0] dig [NSTAGES];
  logic [NSTAGES-1:0] inc, carry;
  logic [4*NSTAGES-1:0] chain_flat;
  logic       ovf_raw;
  int         entry;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], cnt_in};

  assign pulse = sh[1] & ~sh[2];

  always_comb
    case (entry_sel)
      2'b00:   entry = 0;
      2'b01:   entry = 1;
      2'b10:   entry = 3;
      default: entry = 4;
    endcase

  for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign inc[i] = pulse && (entry == i);
    end else begin : g_next
      assign inc[i] = (pulse && (entry == i)) || carry[i-1];
    end
    assign carry[i] = inc[i] && (dig[i] == 4'd9);
    assign chain_flat[4*i +: 4] = dig[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      dig[i] <= '0;
      else if (clr)    dig[i] <= '0;
      else if (inc[i]) dig[i] <= (dig[i] == 4'd9) ? 4'd0 : dig[i] + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ovf_raw <= 1'b0;
    else if (clr)                ovf_raw <= 1'b0;
    else if (carry[NSTAGES-1])   ovf_raw <= 1'b1;

  for (genvar j = 0; j < NSHOW; j++) begin : g_show
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        disp_digits[4*j +: 4] <= '0;
      else if (latch_en) disp_digits[4*j +: 4] <= dig[LOWEST+j];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        disp_ovf <= 1'b0;
    else if (latch_en) disp_ovf <= ovf_raw;
endmodule

module bcd_range_counter_chk #(
  parameter int NSTAGES = 8,
  parameter int NSHOW   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 latch_en,
  input logic                 pulse,
  input logic                 ovf_raw,
  input logic [4*NSTAGES-1:0] chain_flat,
  input logic [4*NSHOW-1:0]   disp_digits,
  input logic                 disp_ovf
);
  always @(negedge clk)
    if (rst_n)
      for (int k = 0; k < NSTAGES; k++)
        p_digit_bcd_r1: assert (chain_flat[4*k +: 4] <= 4'd9)
          else $error("R1 stage %0d not BCD", k);

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  p_latch_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> disp_digits == $past(chain_flat[4*NSTAGES-1 -: 4*NSHOW]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(disp_digits) && $stable(disp_ovf));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_raw && !clr |=> ovf_raw);

  p_ovf_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> disp_ovf == $past(ovf_raw));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> chain_flat == '0 && !ovf_raw);
endmodule

bind bcd_range_counter bcd_range_counter_chk #(.NSTAGES(NSTAGES), .NSHOW(NSHOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .latch_en(latch_en), .pulse(pulse),
  .ovf_raw(ovf_raw), .chain_flat(chain_flat), .disp_digits(disp_digits),
  .disp_ovf(disp_ovf)
);

// File: tb/test_bcd_range_counter.sv
module test_bcd_range_counter;
  logic clk = 1'b0, rst_n = 1'b0, cnt_in = 1'b0, clr = 1'b0, latch_en = 1'b0;
  logic [1:0] entry_sel = 2'b10;
  logic [19:0] disp_digits;
  logic disp_ovf;

  always #4 clk = ~clk;

  bcd_range_counter i_bcd_range_counter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .entry_sel(entry_sel),
    .clr(clr), .latch_en(latch_en), .disp_digits(disp_digits), .disp_ovf(disp_ovf)
  );

  // behavioural model: chain value as one integer, power-of-ten weights
  longint m_val, m_show;
  bit m_ovf, m_dovf, m_s1, m_s2, m_s3;
  int checks = 0, fails = 0, cycles = 0;
  bit comparing = 0;
  string tag = "R10";

  function automatic longint weight(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 10;
      2'b10: return 1000;
      default: return 10000;
    endcase
  endfunction

  function automatic logic [19:0] to_bcd(longint v);
    logic [19:0] r;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_val = 0; m_show = 0; m_ovf = 0; m_dovf = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit p;
      p = m_s2 & ~m_s3;
      if (latch_en) begin
        m_show = (m_val / 1000) % 100000;   // R4 upper five stages, R5 old value
        m_dovf = m_ovf;                      // R8
      end
      if (clr) begin                         // R9 clear wins
        m_val = 0; m_ovf = 0;
      end else if (p) begin                  // R2 weighted injection, R7 wrap
        m_val = m_val + weight(entry_sel);
        if (m_val >= 100000000) begin
          m_val = m_val - 100000000;
          m_ovf = 1;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_in;   // R3 two flops + edge
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      checks++;
      if (disp_digits !== to_bcd(m_show) || disp_ovf !== m_dovf) begin
        fails++;
        $display("FAIL %s cycle %0d: digits=%h ovf=%b expected digits=%h ovf=%b",
                 tag, cycles, disp_digits, disp_ovf, to_bcd(m_show), m_dovf);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic pulses(int n, int hi, int lo);
    for (int k = 0; k < n; k++) begin
      cnt_in = 1'b1; repeat (hi) @(negedge clk);
      cnt_in = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic latch_once();
    latch_en = 1'b1; @(negedge clk); latch_en = 1'b0; @(negedge clk);
  endtask

  task automatic clear_once();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    comparing = 1;
    tag = "R10 reset state";
    repeat (2) @(negedge clk);

    tag = "R2 R4 R5 stage3 entry";
    entry_sel = 2'b10;
    pulses(25, 2, 2); repeat (4) @(negedge clk);
    latch_once();

    tag = "R6 hold while counting";
    pulses(17, 1, 1); repeat (6) @(negedge clk);

    tag = "R5 latch with count in same cycle";
    latch_en = 1'b1; pulses(30, 1, 2); latch_en = 1'b0; repeat (4) @(negedge clk);

    tag = "R9 clear priority over pulse";
    cnt_in = 1'b1; @(negedge clk); @(negedge clk); clr = 1'b1; latch_en = 1'b1;
    @(negedge clk); clr = 1'b0; latch_en = 1'b0; cnt_in = 1'b0;
    repeat (4) @(negedge clk); latch_once();

    tag = "R1 R2 stage1 carry ripple";
    clear_once(); entry_sel = 2'b01;
    pulses(250, 1, 1); repeat (4) @(negedge clk); latch_once();

    tag = "R1 R2 stage0 entry";
    clear_once(); entry_sel = 2'b00;
    pulses(2345, 1, 1); repeat (4) @(negedge clk); latch_once();

    tag = "R3 slow wide pulses";
    clear_once(); entry_sel = 2'b10;
    pulses(9, 7, 5); repeat (4) @(negedge clk); latch_once();

    tag = "R7 overflow at stage4 entry";
    clear_once(); entry_sel = 2'b11;
    pulses(10003, 1, 1); repeat (4) @(negedge clk);
    tag = "R8 flag shown only after latch";
    repeat (3) @(negedge clk); latch_once();

    tag = "R7 R9 clear drops sticky flag, display keeps it";
    clear_once(); repeat (3) @(negedge clk);
    latch_once(); repeat (2) @(negedge clk);

    tag = "R10 asynchronous reset";
    entry_sel = 2'b10; pulses(12, 1, 1); repeat (4) @(negedge clk); latch_once();
    comparing = 0;
    #1 rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
    comparing = 1; repeat (3) @(negedge clk);

    comparing = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule